// File: doc/BRIEF.md
# Systolic Bit-Serial Multiplier

This block multiplies two unsigned N-bit numbers with a linear chain of N identical cells, so its area grows in step with N. Cell j keeps multiplicand bit j. Multiplier bits move along the chain one cell per clock and pass through a register at every hop. Partial sums move the other way, toward cell 0, and are also registered at every hop. Each cell keeps its carry in a two-stage register loop. Because the two streams move in opposite directions, a multiplier bit is injected only on every second cycle. The cycles in between carry zeros. In exchange for this one-half rate, no path is longer than one full adder.

A `start` pulse on an idle block loads the multiplicand and clears all array state. The caller then presents the multiplier bits one at a time, least significant bit first, on the even cycles of the busy window. The block itself appends the N zero bits that flush out the upper half of the product. Product bits come out of cell 0, least significant bit first, on alternate cycles, each marked by `pvalid`.

Top module: `bitserial_mult`

## Requirements
- R1: A `start` pulse sampled while `busy` is low latches `mcand`, and `busy` is high in the following cycle. Changing `mcand` after that has no effect on the result.
- R2: Number the busy cycles from 0, starting with the first cycle after the accepted start. Multiplier bit k is taken from `mbit` in busy cycle 2k, for k = 0..N-1, only if `mvalid` is high in that cycle. If `mvalid` is low in such a slot, the bit counts as 0. `mbit`/`mvalid` in every other cycle is ignored.
- R3: Product bit k, least significant bit first, is on `pbit` with `pvalid` high in busy cycle 2k+2, for k = 0..2N-1. Exactly 2N valid bits are produced per operation.
- R4: The 2N product bits equal the unsigned product of the multiplicand and the multiplier. For N=3, 7 times 7 gives 110001.
- R5: `pvalid` is never high in two consecutive cycles.
- R6: `busy` is high for exactly the busy cycles 0 through 4N and is low in the cycle after.
- R7: A `start` pulse sampled while `busy` is high is ignored. This includes a pulse in the cycle that carries the final product bit.
- R8: An operation started in the first idle cycle after the previous one gives a correct product, with no carry or sum left over from the earlier operation.
- R9: During reset and directly after it, `busy` and `pvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| mcand | input | N | Multiplicand, captured on an accepted start |
| mbit | input | 1 | Serial multiplier bit |
| mvalid | input | 1 | Qualifies `mbit` in an injection slot |
| pbit | output | 1 | Serial product bit |
| pvalid | output | 1 | `pbit` carries a product bit |
| busy | output | 1 | Operation in progress |

## Verification
The two events that can land in the same cycle are an ignored `start` and the emission of the last product bit. The bench raises `start` with a fresh random multiplicand in busy cycle 4N of every operation, and again in cycle 3. Each operation then begins in the very first idle cycle. The bench judges the result by comparing the full serial product against the arithmetic product of the original operands, and by checking the `busy` and `pvalid` timing against R3 and R6. Random noise is driven on `mbit`/`mvalid` outside the injection slots, and this covers R2.

// File: rtl/bitserial_mult.sv
module bitserial_mult #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] mcand,
  input  logic         mbit,
  input  logic         mvalid,
  output logic         pbit,
  output logic         pvalid,
  output logic         busy
);
  localparam int LAST = 4 * N;
  localparam int CW   = $clog2(LAST + 2);

  logic [N-1:0]  a_q, b_q, s_q, c1_q, c2_q;
  logic [N-1:0]  ps_in, sum, cout;
  logic [CW-1:0] cnt;

  wire take = start && !busy;
  wire slot = busy && !cnt[0] && (cnt < CW'(2 * N));

  assign ps_in = {1'b0, s_q[N-1:1]};

  for (genvar j = 0; j < N; j++) begin : g_cell
    wire pp = a_q[j] & b_q[j];
    assign sum[j]  = pp ^ ps_in[j] ^ c2_q[j];
    assign cout[j] = (pp & ps_in[j]) | (pp & c2_q[j]) | (ps_in[j] & c2_q[j]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      s_q  <= '0;
      c1_q <= '0;
      c2_q <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (take) begin
      a_q  <= mcand;
      b_q  <= '0;
      s_q  <= '0;
      c1_q <= '0;
      c2_q <= '0;
      cnt  <= '0;
      busy <= 1'b1;
    end else begin
      b_q  <= {b_q[N-2:0], slot && mvalid && mbit};
      s_q  <= sum;
      c1_q <= cout;
      c2_q <= c1_q;
      if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(LAST)) busy <= 1'b0;
      end
    end
  end

  assign pbit   = s_q[0];
  assign pvalid = busy && !cnt[0] && (cnt != '0);

  assert_half_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pvalid |=> !pvalid);

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(a_q));

  assert_clean_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (s_q == '0 && c1_q == '0 && c2_q == '0 && b_q == '0 && busy));

  assert_ends_on_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pvalid));

  assert_no_early_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !pvalid);
endmodule

// File: tb/sim_bitserial_mult.sv
`timescale 1ns/1ps
module mult_run #(
  parameter int N     = 3,
  parameter bit SWEEP = 1,
  parameter int RUNS  = 0
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   fails,
  output logic done
);
  logic         start, mbit, mvalid, pbit, pvalid, busy;
  logic [N-1:0] mcand;

  bitserial_mult #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mbit(mbit), .mvalid(mvalid), .pbit(pbit), .pvalid(pvalid), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s N=%0d actual=%0h expected=%0h", req, N, act, exp);
    end
  endtask

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-1:0] exp, got;
    int nb;
    exp = (2*N)'(a) * (2*N)'(b);
    got = '0;
    nb  = 0;
    start = 1'b1; mcand = a; mvalid = 1'b0;
    @(negedge clk);
    start = 1'b0; mcand = ~a;
    chk(busy === 1'b1, "R1", busy, 1);
    for (int i = 0; i <= 4*N; i++) begin
      chk(busy === 1'b1, "R6", busy, 1);
      if (i % 2 == 0 && i >= 2) begin
        chk(pvalid === 1'b1, "R3", pvalid, 1);
        got[(i-2)/2] = pbit;
        if (pvalid === 1'b1) nb++;
      end else begin
        chk(pvalid === 1'b0, "R5", pvalid, 0);
      end
      if (i % 2 == 0 && i < 2*N) begin
        if (!b[i/2] && ($urandom % 2 == 1)) begin
          mvalid = 1'b0; mbit = 1'b1;   // R2: missing strobe means zero
        end else begin
          mvalid = 1'b1; mbit = b[i/2];
        end
      end else begin
        mvalid = 1'($urandom % 2);      // R2: off-slot noise
        mbit   = 1'($urandom % 2);
      end
      start = (i == 4*N) || (i == 3);   // R7: ignored while busy
      mcand = N'($urandom);
      @(negedge clk);
    end
    start = 1'b0; mvalid = 1'b0;
    chk(busy === 1'b0, "R6", busy, 0);
    chk(pvalid === 1'b0, "R5", pvalid, 0);
    chk(got === exp, "R4", longint'(got), longint'(exp));  // R8: back-to-back ops
    chk(nb == 2*N, "R3", nb, 2*N);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    start = 1'b0; mcand = '0; mbit = 1'b0; mvalid = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && pvalid === 1'b0, "R9", {busy, pvalid}, 0);
    wait (rst_n === 1'b1);
    @(negedge clk);
    chk(busy === 1'b0 && pvalid === 1'b0, "R9", {busy, pvalid}, 0);
    run_op('1, '1);
    if (SWEEP) begin
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          run_op(N'(a), N'(b));
    end else begin
      for (int r = 0; r < RUNS; r++)
        run_op(N'($urandom), N'($urandom));
      run_op('0, '1);
      run_op('1, '0);
    end
    done = 1'b1;
  end
endmodule

module sim_bitserial_mult;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int c3, f3, c4, f4, c8, f8;
  logic d3, d4, d8;

  always #2.5 clk = ~clk;

  mult_run #(.N(3), .SWEEP(1), .RUNS(0))   r3 (.clk(clk), .rst_n(rst_n), .checks(c3), .fails(f3), .done(d3));
  mult_run #(.N(4), .SWEEP(1), .RUNS(0))   r4 (.clk(clk), .rst_n(rst_n), .checks(c4), .fails(f4), .done(d4));
  mult_run #(.N(8), .SWEEP(0), .RUNS(300)) r8 (.clk(clk), .rst_n(rst_n), .checks(c8), .fails(f8), .done(d8));

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
  end

  initial begin
    int t;
    int bad;
    int total;
    t = 0;
    while (!(d3 === 1'b1 && d4 === 1'b1 && d8 === 1'b1) && t < 150000) begin
      @(posedge clk);
      t++;
    end
    total = c3 + c4 + c8;
    bad   = f3 + f4 + f8;
    if (t >= 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", t);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule